// File: doc/BRIEF.md
# Serial Register-Access Port

This block is the serial front end of a small configuration and status register bank. An external controller drives chip-select, a serial clock and a data line. The block oversamples those three lines with its own system clock and assembles 16-bit command frames. Each frame carries a direction flag, a register address and an 11-bit payload. As soon as the address is complete, the block fetches the addressed register. It then shifts that value back to the controller during the rest of the same frame.

A write or a read is committed only after chip-select returns high, and only if the frame held exactly 16 serial clocks. A write commits as a one-cycle write strobe with address and data. A read commits as a one-cycle read request. A frame of any other length produces a one-cycle error pulse and nothing else. The register contents, any lock policy and the pad tri-state buffer are outside this block. The block supplies the output-enable for that buffer.

The system clock must run at least 8 times faster than the serial clock. The serial clock must be low whenever chip-select changes.

Top module: `spi_regport`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Serial data is captured on falling serial-clock edges. Bit 15 selects the direction (1 = read, 0 = write). Bits 14..11 hold the address. Bits 10..0 hold the write payload.
- R2: After a 16-clock frame with bit 15 = 0, reg_we pulses high for exactly one system cycle after chip-select rises. During that pulse, reg_addr and reg_wdata carry the frame's address and payload, and reg_re stays low.
- R3: After a 16-clock frame with bit 15 = 1, reg_re pulses high for exactly one system cycle after chip-select rises, and reg_we stays low.
- R4: The output word is sent most significant bit first and changes after rising serial-clock edges. Its first 5 bit times are driven 0. The remaining 11 bit times carry the addressed register as fetched once the address was complete. On a write, this is the value from before the write.
- R5: A frame with fewer or more than 16 serial clocks produces exactly one one-cycle frame_error pulse after chip-select rises. It produces no write strobe and no read request, and leaves the register bank unchanged.
- R6: While chip-select is high, serial-clock and data activity is ignored and sdo_oe is low. While a frame is open, sdo_oe is high.
- R7: During and directly after reset, sdo, sdo_oe, reg_we, reg_re and frame_error are low.
- R8: reg_addr takes the frame's address after the fifth captured bit. It holds that value until a later frame completes its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select from the controller, active low |
| sclk | input | 1 | Serial clock, low at chip-select edges |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| sdo_oe | output | 1 | Output-enable for the sdo pad buffer |
| reg_addr | output | ADDR_W (4) | Register address toward the bank |
| reg_wdata | output | DATA_W (11) | Write payload, valid with reg_we |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | DATA_W (11) | Contents of the register at reg_addr, same cycle |
| frame_error | output | 1 | One-cycle pulse for a frame of wrong length |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 11-bit payload, a 16-bit frame and a two-stage synchroniser. It runs the serial clock at ten system cycles per period. With a 4-bit address, the bench's bank model can reach both the lowest and the highest address, and an all-ones payload fills every data bit. A 3-bit, a 15-bit and a 17-bit frame take the bit counter below the header boundary, just short of a full frame, and into its saturation value.

// File: rtl/spi_regport_pkg.sv
// Shared constants and types for the serial register-access port.
// Assumes: frame = 1 direction bit + address + payload.
package spi_regport_pkg;

    localparam int ADDR_W_DEF = 4;
    localparam int DATA_W_DEF = 11;
    localparam int SYNC_DEF   = 2;

    typedef enum logic {
        CMD_WRITE = 1'b0,
        CMD_READ  = 1'b1
    } cmd_e;

    // Counter width able to hold frame_bits + 1 (saturation value for long frames).
    function automatic int cnt_width(input int frame_bits);
        return $clog2(frame_bits + 2);
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
// Multi-stage synchroniser with edge detection for a vector of asynchronous lines.
// Assumes: STAGES >= 2; all lines share one depth, so their relative timing is kept.
module spi_regport_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [W-1:0]             last_q;

    // Shift the raw lines through the synchroniser and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
            last_q <= RST_VAL;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = level & ~last_q;
    assign fall  = ~level & last_q;

endmodule

// File: rtl/spi_regport_rx.sv
// Receive side: counts captured bits, shifts in data, decodes the header
// and commits a strobe or flags an error when chip-select closes the frame.
// Assumes: ADDR_W >= 2; inputs are already synchronised single-cycle events.
module spi_regport_rx
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CNT_W  = cnt_width(1 + ADDR_W + DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              hdr_done,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              re,
    output logic              frame_err
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

    logic [FRAME_BITS-1:0] shift_q;
    cmd_e                  cmd_q;

    // Frame capture, header decode and end-of-frame commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shift_q   <= '0;
            addr      <= '0;
            cmd_q     <= CMD_WRITE;
            hdr_done  <= 1'b0;
            we        <= 1'b0;
            re        <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            hdr_done  <= 1'b0;
            we        <= 1'b0;
            re        <= 1'b0;
            frame_err <= 1'b0;
            if (cs_start) begin
                bit_cnt <= '0;
            end else if (cs_active && sclk_fall) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], sdi_s};
                if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (bit_cnt == CNT_HDR) begin
                    addr     <= {shift_q[ADDR_W-2:0], sdi_s};
                    cmd_q    <= cmd_e'(shift_q[ADDR_W-1]);
                    hdr_done <= 1'b1;
                end
            end else if (cs_end) begin
                if (bit_cnt == CNT_FULL) begin
                    we <= (cmd_q == CMD_WRITE);
                    re <= (cmd_q == CMD_READ);
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    assign wdata = shift_q[DATA_W-1:0];

endmodule

// File: rtl/spi_regport_tx.sv
// Transmit side: loads the fetched register once the header is complete and
// shifts it out MSB first on rising serial-clock events after the header bits.
// Assumes: load arrives before the next rising serial-clock event (8x oversampling).
module spi_regport_tx #(
    parameter int DATA_W     = 11,
    parameter int HDR_BITS   = 5,
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              sclk_rise,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              load,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo
);

    logic [DATA_W-1:0] tx_q;
    logic              in_payload;

    assign in_payload = (bit_cnt >= CNT_W'(HDR_BITS)) && (bit_cnt < CNT_W'(FRAME_BITS));

    // Response shifter: zeros during the header, register data afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            sdo  <= 1'b0;
        end else if (cs_start) begin
            tx_q <= '0;
            sdo  <= 1'b0;
        end else if (load) begin
            tx_q <= rdata;
        end else if (sclk_rise && in_payload) begin
            sdo  <= tx_q[DATA_W-1];
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_regport.sv
// Top of the serial register-access port: synchronises the serial lines into
// clk, frames 16-bit commands and talks to an external register bank.
// Assumes: clk >= 8x serial clock; reg_rdata follows reg_addr combinationally.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              frame_error
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int CNT_W      = cnt_width(FRAME_BITS);

    // Line order inside the synchroniser vector: {sdi, sclk, cs_n}.
    logic [2:0]       s_lvl;
    logic [2:0]       s_rise;
    logic [2:0]       s_fall;
    logic             cs_active;
    logic             cs_start;
    logic             cs_end;
    logic [CNT_W-1:0] bit_cnt;
    logic             hdr_done;

    spi_regport_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdi, sclk, cs_n}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    assign cs_active = ~s_lvl[0];
    assign cs_start  = s_fall[0];
    assign cs_end    = s_rise[0];
    assign sdo_oe    = cs_active;

    spi_regport_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .sclk_fall (s_fall[1]),
        .sdi_s     (s_lvl[2]),
        .bit_cnt   (bit_cnt),
        .hdr_done  (hdr_done),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .re        (reg_re),
        .frame_err (frame_error)
    );

    spi_regport_tx #(
        .DATA_W     (DATA_W),
        .HDR_BITS   (HDR_BITS),
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_start  (cs_start),
        .sclk_rise (s_rise[1]),
        .bit_cnt   (bit_cnt),
        .load      (hdr_done),
        .rdata     (reg_rdata),
        .sdo       (sdo)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Protocol checker for spi_regport, attached by bind below.
// Assumes: it observes the top's synchronised frame-end event and bit counter.
module spi_regport_chk #(
    parameter int CNT_W      = 5,
    parameter int FRAME_BITS = 16,
    parameter int HDR_BITS   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_end,
    input logic             hdr_done,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             reg_we,
    input logic             reg_re,
    input logic             frame_error,
    input logic             sdo_oe,
    input logic             cs_n
);

    // R2/R3: a commit only follows the close of a frame.
    a_r2_commit_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> $past(cs_end));

    // R3: write strobe and read request never together.
    a_r3_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R5: an error pulse carries no commit and lasts one cycle.
    a_r5_error_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> !(reg_we || reg_re));

    a_r5_error_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> !frame_error);

    // R5: the bit counter never passes its saturation value.
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS + 1));

    // R8: the header is decoded exactly when the fifth bit has been counted.
    a_r8_header_at_fifth: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> (bit_cnt == CNT_W'(HDR_BITS)));

    // R6: the output driver is off after chip-select has been high for the sync depth.
    a_r6_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 3) && $past(cs_n, 2) && $past(cs_n, 1) && cs_n) |-> !sdo_oe);

endmodule

bind spi_regport spi_regport_chk #(
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS),
    .HDR_BITS   (HDR_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_end      (cs_end),
    .hdr_done    (hdr_done),
    .bit_cnt     (bit_cnt),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .frame_error (frame_error),
    .sdo_oe      (sdo_oe),
    .cs_n        (cs_n)
);

// File: tb/spi_regport_tb_top.sv
// Self-checking bench: a register-bank model, a serial master task,
// a vector table walked by one loop, then directed reset and idle tests.
module spi_regport_tb_top;

    localparam int AW = 4;
    localparam int DW = 11;
    localparam int NREG = 1 << AW;
    localparam int NVEC = 15;

    // Vector fields: {clock count[4:0], read flag, address[3:0], payload[10:0]}.
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd16, 1'b0, 4'd2,  11'h155},
        {5'd16, 1'b1, 4'd2,  11'h000},
        {5'd16, 1'b0, 4'd15, 11'h7FF},
        {5'd16, 1'b1, 4'd15, 11'h000},
        {5'd16, 1'b0, 4'd0,  11'h000},
        {5'd16, 1'b1, 4'd0,  11'h000},
        {5'd15, 1'b0, 4'd3,  11'h2AA},
        {5'd16, 1'b1, 4'd3,  11'h000},
        {5'd17, 1'b0, 4'd3,  11'h123},
        {5'd16, 1'b1, 4'd3,  11'h000},
        {5'd3,  1'b1, 4'd7,  11'h000},
        {5'd16, 1'b1, 4'd7,  11'h000},
        {5'd16, 1'b0, 4'd9,  11'h4C3},
        {5'd16, 1'b0, 4'd9,  11'h0F0},
        {5'd16, 1'b1, 4'd9,  11'h000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          sclk;
    logic          sdi;
    logic          sdo;
    logic          sdo_oe;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_we;
    logic          reg_re;
    logic [DW-1:0] reg_rdata;
    logic          frame_error;

    logic [DW-1:0] bank  [NREG];
    logic [DW-1:0] model [NREG];

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int err_cnt = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_regport dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .reg_rdata   (reg_rdata),
        .frame_error (frame_error)
    );

    function automatic logic [DW-1:0] init_val(input int i);
        return DW'((i * 181 + 77) % (1 << DW));
    endfunction

    // External register bank driven by the block's strobes.
    assign reg_rdata = bank[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= init_val(i);
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
        end
    end

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                we_cnt++;
                last_waddr = reg_addr;
                last_wdata = reg_wdata;
            end
            if (reg_re) re_cnt++;
            if (frame_error) err_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Serial master: 10 system cycles per serial clock, sample sdo on falling edges.
    task automatic spi_frame(input logic [15:0] word, input int nbits,
                             output logic [15:0] resp, output logic oe_seen);
        resp = '0;
        oe_seen = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 16) ? word[15-i] : 1'b0;
            sclk = 1'b1;
            repeat (5) @(negedge clk);
            sclk = 1'b0;
            if (i < 16) resp[15-i] = sdo;
            if (sdo_oe) oe_seen = 1'b1;
            repeat (5) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] resp;
        logic        oe_seen;
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b0;
        sdi   = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = init_val(i);
        repeat (5) @(negedge clk);
        // R7: outputs quiet during reset.
        check("R7 reset outputs", {27'd0, sdo, sdo_oe, reg_we, reg_re, frame_error}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 after reset outputs", {27'd0, sdo, sdo_oe, reg_we, reg_re, frame_error}, 32'd0);

        // Table of frames.
        for (int v = 0; v < NVEC; v++) begin
            int            nb;
            logic          rw;
            logic [AW-1:0] ad;
            logic [DW-1:0] dt;
            int            we0;
            int            re0;
            int            er0;
            nb  = int'(VEC[v][20:16]);
            rw  = VEC[v][15];
            ad  = VEC[v][14:11];
            dt  = VEC[v][10:0];
            we0 = we_cnt;
            re0 = re_cnt;
            er0 = err_cnt;
            spi_frame({rw, ad, dt}, nb, resp, oe_seen);
            if (nb == 16) begin
                check("R4 response word", {16'd0, resp}, {16'd0, 5'd0, model[ad]});
                check("R8 address held", {28'd0, reg_addr}, {28'd0, ad});
                check("R6 driver on in frame", {31'd0, oe_seen}, 32'd1);
                check("R5 no error on full frame", err_cnt, er0);
                if (rw) begin
                    check("R3 one read request", re_cnt, re0 + 1);
                    check("R3 no write strobe", we_cnt, we0);
                end else begin
                    check("R2 one write strobe", we_cnt, we0 + 1);
                    check("R2 no read request", re_cnt, re0);
                    check("R1 write address", {28'd0, last_waddr}, {28'd0, ad});
                    check("R1 write payload", {21'd0, last_wdata}, {21'd0, dt});
                    model[ad] = dt;
                end
            end else begin
                check("R5 one error pulse", err_cnt, er0 + 1);
                check("R5 no write on bad frame", we_cnt, we0);
                check("R5 no read on bad frame", re_cnt, re0);
            end
        end

        // R6: activity with chip-select high is ignored.
        begin
            int we0;
            int re0;
            int er0;
            we0 = we_cnt;
            re0 = re_cnt;
            er0 = err_cnt;
            for (int k = 0; k < 20; k++) begin
                sdi  = k[0];
                sclk = 1'b1;
                repeat (5) @(negedge clk);
                check("R6 driver off while idle", {31'd0, sdo_oe}, 32'd0);
                sclk = 1'b0;
                repeat (5) @(negedge clk);
            end
            repeat (10) @(negedge clk);
            check("R6 idle clocks no error", err_cnt, er0);
            check("R6 idle clocks no strobe", we_cnt + re_cnt, we0 + re0);
            spi_frame({1'b1, 4'd2, 11'd0}, 16, resp, oe_seen);
            check("R6 frame after idle clocks", {16'd0, resp}, {16'd0, 5'd0, model[2]});
            check("R6 read after idle clocks", re_cnt, re0 + 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule